// File: doc/BRIEF.md
# Block Move and Swap Engine for Wide Search Memories

This engine takes one command at a time. Each command is an opcode plus a packed 64-bit parameter word. It then moves or exchanges a block of 68-bit entries in a set of search-engine memories. A 5-bit device ID selects each memory, and each memory is addressed by a 16-bit word pointer. All memories share one synchronous access port, and that port carries one access per cycle.

A Move copies a block from a source region to a destination region. The engine first reads the whole source block into an internal buffer, then writes the whole buffer to the destination. Overlapping regions therefore copy cleanly. A Swap reads the first region and then the second region, each into its own buffer bank. It then writes the second region's data to the first address and the first region's data to the second address, so the two regions trade contents.

A command with a bad length, with a region that runs off the end of its device, or with an unknown opcode is rejected at once. A rejected command raises an error pulse and makes no memory access. A finished command raises a single-cycle done pulse.

Top module: `xs_move_swap_engine`

## Requirements
- R1: The parameter word holds the first (source) address in bits 15:0, the first device ID in bits 23:19, the second (destination) address in bits 39:24, the second device ID in bits 47:43 and the length in entries in bits 56:48. Opcode 0x05 selects Swap and opcode 0x04 selects Move.
- R2: A Move issues its reads in consecutive cycles, starting in the cycle after the command is accepted. There are `len` reads, to source addresses start, start+1, and so on. The writes follow at once, `len` of them, in consecutive cycles, to the destination addresses in the same order.
- R3: After a Move, the destination holds the original source contents. This holds even when the two regions overlap. Entries outside the destination region are unchanged.
- R4: A Swap issues, in consecutive cycles, `len` reads of the first region, then `len` reads of the second region, then `len` writes to the first region, then `len` writes to the second region. Each run uses incrementing addresses.
- R5: After a Swap, the first region holds the old contents of the second region and the second region holds the old contents of the first.
- R6: A length below 4 or above 128 rejects the command. `err_o` is high for exactly the cycle after acceptance, no memory access is made and `cmd_ready_o` stays high.
- R7: A region with start + len greater than 65536 rejects the command in the same way as R6. A region that ends exactly at the last device address is accepted.
- R8: `done_o` is high for exactly one cycle, the cycle after the last write. `cmd_ready_o` is low from acceptance until that cycle. `cmd_valid_i` has no effect while the engine is busy.
- R9: Bits 18:16, 42:40 and 63:57 of the parameter word have no effect.
- R10: After reset, `cmd_ready_o` is 1 and `mem_en_o`, `done_o` and `err_o` are 0.
- R11: Any opcode other than 0x04 or 0x05 is rejected in the same way as R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Engine idle; the command is taken on valid and ready |
| cmd_op_i | input | 8 | Command opcode |
| cmd_param_i | input | 64 | Packed region descriptor |
| mem_en_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_dev_o | output | 5 | Device ID of the access |
| mem_addr_o | output | 16 | Word address within the device |
| mem_wdata_o | output | 68 | Write data |
| mem_rdata_i | input | 68 | Read data, valid the cycle after a read |
| done_o | output | 1 | Command completed, one-cycle pulse |
| err_o | output | 1 | Command rejected, one-cycle pulse |

## Verification
The first memory access of an accepted command is due in the cycle right after the accepting edge. After that, one access is due every cycle with no gaps, and `done_o` is due in the cycle after the last write. An error pulse is due in the cycle after acceptance, and it must come with no access. The bench drives and samples on the falling edge, and it advances exactly one cycle for each expected access. Any dropped, extra or shifted access therefore shows up as a mismatch at that exact cycle. Memory contents are compared only after the done pulse, against a reference that the bench updates with a read-all-then-write rule.

// File: rtl/xs_pkg.sv
package xs_pkg;
   // descriptor format widths (fixed by the command format)
   localparam int unsigned PARAM_W = 64;
   localparam int unsigned OP_W    = 8;
   localparam int unsigned ADDR_W  = 16;
   localparam int unsigned DEV_W   = 5;
   localparam int unsigned LEN_W   = 9;

   // field positions inside the parameter word
   localparam int unsigned A_ADDR_LSB = 0;
   localparam int unsigned A_DEV_LSB  = 19;
   localparam int unsigned B_ADDR_LSB = 24;
   localparam int unsigned B_DEV_LSB  = 43;
   localparam int unsigned LEN_LSB    = 48;

   localparam logic [OP_W-1:0] OP_MOVE = 8'h04;
   localparam logic [OP_W-1:0] OP_SWAP = 8'h05;

   typedef struct packed {
      logic              swap;
      logic [DEV_W-1:0]  a_dev;
      logic [ADDR_W-1:0] a_addr;
      logic [DEV_W-1:0]  b_dev;
      logic [ADDR_W-1:0] b_addr;
      logic [LEN_W-1:0]  len;
   } xs_desc_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_A,
      ST_RD_B,
      ST_WR_A,
      ST_WR_B
   } xs_state_e;
endpackage

// File: rtl/xs_cmd_check.sv
module xs_cmd_check
   import xs_pkg::*;
#(
   parameter int unsigned MIN_LEN   = 4,
   parameter int unsigned MAX_LEN   = 128,
   parameter int unsigned DEV_WORDS = 65536
)(
   input  logic [OP_W-1:0]    op_i,
   input  logic [PARAM_W-1:0] param_i,
   output xs_desc_t           desc_o,
   output logic               ok_o
);
   localparam int unsigned     END_W   = ADDR_W + 1;
   localparam logic [LEN_W-1:0] MIN_L  = LEN_W'(MIN_LEN);
   localparam logic [LEN_W-1:0] MAX_L  = LEN_W'(MAX_LEN);
   localparam logic [END_W-1:0] LIMIT  = END_W'(DEV_WORDS);

   if (MIN_LEN < 2 || MIN_LEN > MAX_LEN || MAX_LEN >= (1 << LEN_W)) begin : g_bad_len
      $error("xs_cmd_check: length limits out of range");
   end
   if (DEV_WORDS < 1 || DEV_WORDS > (1 << ADDR_W)) begin : g_bad_dev
      $error("xs_cmd_check: device size out of range");
   end

   logic             op_known;
   logic             len_ok;
   logic             a_fits;
   logic             b_fits;
   logic [END_W-1:0] a_end;
   logic [END_W-1:0] b_end;

   // only the defined fields are extracted; reserved bits never reach logic
   always_comb begin
      desc_o.swap   = (op_i == OP_SWAP);
      desc_o.a_addr = param_i[A_ADDR_LSB +: ADDR_W];
      desc_o.a_dev  = param_i[A_DEV_LSB  +: DEV_W];
      desc_o.b_addr = param_i[B_ADDR_LSB +: ADDR_W];
      desc_o.b_dev  = param_i[B_DEV_LSB  +: DEV_W];
      desc_o.len    = param_i[LEN_LSB    +: LEN_W];
   end

   assign op_known = (op_i == OP_SWAP) || (op_i == OP_MOVE);
   assign len_ok   = (desc_o.len >= MIN_L) && (desc_o.len <= MAX_L);
   assign a_end    = END_W'(desc_o.a_addr) + END_W'(desc_o.len);
   assign b_end    = END_W'(desc_o.b_addr) + END_W'(desc_o.len);
   assign a_fits   = (a_end <= LIMIT);
   assign b_fits   = (b_end <= LIMIT);
   assign ok_o     = op_known && len_ok && a_fits && b_fits;
endmodule

// File: rtl/xs_swap_buffer.sv
module xs_swap_buffer #(
   parameter  int unsigned DATA_W = 68,
   parameter  int unsigned DEPTH  = 128,
   localparam int unsigned IDX_W  = $clog2(DEPTH)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic              wr_bank_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              rd_en_i,
   input  logic              rd_bank_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [DATA_W-1:0] rd_data_o
);
   localparam int unsigned NBANK = 2;

   if (DEPTH < 2 || DATA_W < 1) begin : g_bad_cfg
      $error("xs_swap_buffer: bad geometry");
   end

   logic [DATA_W-1:0] bank_rd [NBANK];

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      logic [DATA_W-1:0] store [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_en_i && (wr_bank_i == 1'(g))) begin
            store[wr_idx_i] <= wr_data_i;
         end
      end
      assign bank_rd[g] = store[rd_idx_i];
   end

   assign rd_data_o = bank_rd[rd_bank_i];

   // an entry must never be drained in the same cycle it is being filled
   assert_no_rw_clash_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && rd_en_i) |-> !((wr_bank_i == rd_bank_i) && (wr_idx_i == rd_idx_i)))
      else $error("buffer fill and drain hit the same entry");
endmodule

// File: rtl/xs_sequencer.sv
module xs_sequencer
   import xs_pkg::*;
#(
   parameter  int unsigned MIN_LEN = 4,
   parameter  int unsigned MAX_LEN = 128,
   localparam int unsigned IDX_W   = $clog2(MAX_LEN)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  xs_desc_t          desc_i,
   output logic              busy_o,
   output logic              mem_en_o,
   output logic              mem_we_o,
   output logic [DEV_W-1:0]  mem_dev_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              cap_en_o,
   output logic              cap_bank_o,
   output logic [IDX_W-1:0]  cap_idx_o,
   output logic              src_bank_o,
   output logic [IDX_W-1:0]  src_idx_o,
   output logic              done_o
);
   localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
   localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

   xs_state_e        state_q;
   xs_state_e        state_nxt;
   xs_desc_t         desc_q;
   logic [LEN_W-1:0] cnt_q;
   logic             last;
   logic             use_a;
   logic             rd_now;
   logic             done_q;
   logic             cap_en_q;
   logic             cap_bank_q;
   logic [IDX_W-1:0] cap_idx_q;

   assign last   = (cnt_q == (desc_q.len - LEN_W'(1)));
   assign use_a  = (state_q == ST_RD_A) || (state_q == ST_WR_A);
   assign rd_now = (state_q == ST_RD_A) || (state_q == ST_RD_B);

   // phase order: Move = RD_A, WR_B ; Swap = RD_A, RD_B, WR_A, WR_B
   always_comb begin
      unique case (state_q)
         ST_RD_A: state_nxt = desc_q.swap ? ST_RD_B : ST_WR_B;
         ST_RD_B: state_nxt = ST_WR_A;
         ST_WR_A: state_nxt = ST_WR_B;
         default: state_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         desc_q     <= '0;
         cnt_q      <= '0;
         done_q     <= 1'b0;
         cap_en_q   <= 1'b0;
         cap_bank_q <= 1'b0;
         cap_idx_q  <= '0;
      end else begin
         done_q     <= 1'b0;
         cap_en_q   <= rd_now;
         cap_bank_q <= (state_q == ST_RD_B);
         cap_idx_q  <= cnt_q[IDX_W-1:0];
         if (state_q == ST_IDLE) begin
            if (start_i) begin
               desc_q  <= desc_i;
               cnt_q   <= '0;
               state_q <= ST_RD_A;
            end
         end else if (last) begin
            cnt_q   <= '0;
            state_q <= state_nxt;
            done_q  <= (state_q == ST_WR_B);
         end else begin
            cnt_q <= cnt_q + LEN_W'(1);
         end
      end
   end

   assign busy_o     = (state_q != ST_IDLE);
   assign mem_en_o   = busy_o;
   assign mem_we_o   = (state_q == ST_WR_A) || (state_q == ST_WR_B);
   assign mem_dev_o  = use_a ? desc_q.a_dev : desc_q.b_dev;
   assign mem_addr_o = (use_a ? desc_q.a_addr : desc_q.b_addr) + ADDR_W'(cnt_q);
   assign cap_en_o   = cap_en_q;
   assign cap_bank_o = cap_bank_q;
   assign cap_idx_o  = cap_idx_q;
   // bank 1 holds the second region, which is written to the first address
   assign src_bank_o = (state_q == ST_WR_A);
   assign src_idx_o  = cnt_q[IDX_W-1:0];
   assign done_o     = done_q;

   assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en_o && $past(mem_en_o) && (state_q == $past(state_q)))
         |-> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1)))
      else $error("burst address did not step by one");

   assert_len_bounds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> ((desc_i.len >= MIN_L) && (desc_i.len <= MAX_L)))
      else $error("start with illegal length");

   assert_start_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o)
      else $error("start while busy");

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o)
      else $error("done longer than one cycle");

   assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(mem_we_o))
      else $error("done without a preceding write");
endmodule

// File: rtl/xs_move_swap_engine.sv
module xs_move_swap_engine
   import xs_pkg::*;
#(
   parameter int unsigned DATA_W    = 68,
   parameter int unsigned MIN_LEN   = 4,
   parameter int unsigned MAX_LEN   = 128,
   parameter int unsigned DEV_WORDS = 65536
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid_i,
   output logic               cmd_ready_o,
   input  logic [OP_W-1:0]    cmd_op_i,
   input  logic [PARAM_W-1:0] cmd_param_i,
   output logic               mem_en_o,
   output logic               mem_we_o,
   output logic [DEV_W-1:0]   mem_dev_o,
   output logic [ADDR_W-1:0]  mem_addr_o,
   output logic [DATA_W-1:0]  mem_wdata_o,
   input  logic [DATA_W-1:0]  mem_rdata_i,
   output logic               done_o,
   output logic               err_o
);
   localparam int unsigned IDX_W = $clog2(MAX_LEN);

   xs_desc_t         desc;
   logic             desc_ok;
   logic             accept;
   logic             start;
   logic             busy;
   logic             err_q;
   logic             cap_en;
   logic             cap_bank;
   logic [IDX_W-1:0] cap_idx;
   logic             src_bank;
   logic [IDX_W-1:0] src_idx;

   xs_cmd_check #(
      .MIN_LEN   (MIN_LEN),
      .MAX_LEN   (MAX_LEN),
      .DEV_WORDS (DEV_WORDS)
   ) i_check (
      .op_i    (cmd_op_i),
      .param_i (cmd_param_i),
      .desc_o  (desc),
      .ok_o    (desc_ok)
   );

   assign cmd_ready_o = !busy;
   assign accept      = cmd_valid_i && cmd_ready_o;
   assign start       = accept && desc_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= accept && !desc_ok;
   end
   assign err_o = err_q;

   xs_sequencer #(
      .MIN_LEN (MIN_LEN),
      .MAX_LEN (MAX_LEN)
   ) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .desc_i     (desc),
      .busy_o     (busy),
      .mem_en_o   (mem_en_o),
      .mem_we_o   (mem_we_o),
      .mem_dev_o  (mem_dev_o),
      .mem_addr_o (mem_addr_o),
      .cap_en_o   (cap_en),
      .cap_bank_o (cap_bank),
      .cap_idx_o  (cap_idx),
      .src_bank_o (src_bank),
      .src_idx_o  (src_idx),
      .done_o     (done_o)
   );

   xs_swap_buffer #(
      .DATA_W (DATA_W),
      .DEPTH  (MAX_LEN)
   ) i_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (cap_en),
      .wr_bank_i (cap_bank),
      .wr_idx_i  (cap_idx),
      .wr_data_i (mem_rdata_i),
      .rd_en_i   (mem_we_o),
      .rd_bank_i (src_bank),
      .rd_idx_i  (src_idx),
      .rd_data_o (mem_wdata_o)
   );

   assert_reject_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !mem_en_o)
      else $error("rejected command touched memory");

   assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en_o |-> !cmd_ready_o)
      else $error("ready while accessing memory");

   assert_done_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o))
      else $error("done and error together");
endmodule

// File: tb/test_xs_move_swap_engine.sv
`timescale 1ns/1ps
module test_xs_move_swap_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [7:0]  cmd_op = 8'h00;
   logic [63:0] cmd_param = 64'h0;
   logic        mem_en;
   logic        mem_we;
   logic [4:0]  mem_dev;
   logic [15:0] mem_addr;
   logic [67:0] mem_wdata;
   logic [67:0] mem_rdata = 68'h0;
   logic        done;
   logic        err;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;   // 250 MHz

   xs_move_swap_engine i_xs_move_swap_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid_i (cmd_valid),
      .cmd_ready_o (cmd_ready),
      .cmd_op_i    (cmd_op),
      .cmd_param_i (cmd_param),
      .mem_en_o    (mem_en),
      .mem_we_o    (mem_we),
      .mem_dev_o   (mem_dev),
      .mem_addr_o  (mem_addr),
      .mem_wdata_o (mem_wdata),
      .mem_rdata_i (mem_rdata),
      .done_o      (done),
      .err_o       (err)
   );

   // ---------------- memory model and reference ----------------
   bit [67:0] dmem [int];
   bit [67:0] rmem [int];

   function automatic bit [67:0] patt(int k);
      bit [4:0]  d = k[20:16];
      bit [15:0] a = k[15:0];
      return {d, a, ~a, d ^ 5'h15, a[9:0], 16'h5A3C};
   endfunction
   function automatic int key(bit [4:0] d, bit [15:0] a);
      return int'({d, a});
   endfunction
   function automatic bit [67:0] dval(int k);
      return dmem.exists(k) ? dmem[k] : patt(k);
   endfunction
   function automatic bit [67:0] rval(int k);
      return rmem.exists(k) ? rmem[k] : patt(k);
   endfunction

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) dmem[key(mem_dev, mem_addr)] = mem_wdata;
         else        mem_rdata <= dval(key(mem_dev, mem_addr));
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [67:0] act, input logic [67:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // ---------------- vector table ----------------
   function automatic logic [72:0] mkv(logic [7:0] op, logic [4:0] ad, logic [15:0] aa,
                                       logic [4:0] bd, logic [15:0] ba, logic [8:0] ln,
                                       bit resv, bit er);
      logic [63:0] p = '0;
      if (resv) begin
         p[18:16] = '1; p[42:40] = '1; p[63:57] = '1;
      end
      p[15:0] = aa; p[23:19] = ad; p[39:24] = ba; p[47:43] = bd; p[56:48] = ln;
      return {op, p, er};
   endfunction

   localparam int NV = 11;
   localparam logic [72:0] VEC [NV] = '{
      mkv(8'h04, 5'd1, 16'h0100, 5'd2, 16'h0200, 9'd4,   1'b0, 1'b0), // R2 R3 min length
      mkv(8'h04, 5'd3, 16'h0010, 5'd3, 16'h0400, 9'd128, 1'b0, 1'b0), // R2 R3 max length
      mkv(8'h05, 5'd1, 16'h0300, 5'd4, 16'h0050, 9'd9,   1'b0, 1'b0), // R4 R5
      mkv(8'h05, 5'd0, 16'h1000, 5'd0, 16'h2000, 9'd128, 1'b1, 1'b0), // R9 reserved all ones
      mkv(8'h04, 5'd1, 16'h0000, 5'd2, 16'h0000, 9'd3,   1'b0, 1'b1), // R6 too short
      mkv(8'h05, 5'd1, 16'h0000, 5'd2, 16'h0800, 9'd129, 1'b0, 1'b1), // R6 too long
      mkv(8'h04, 5'd6, 16'hFFFC, 5'd7, 16'h0020, 9'd4,   1'b0, 1'b0), // R7 ends at last word
      mkv(8'h05, 5'd6, 16'h0040, 5'd7, 16'hFFFD, 9'd4,   1'b0, 1'b1), // R7 runs past end
      mkv(8'h07, 5'd1, 16'h0000, 5'd2, 16'h0000, 9'd8,   1'b0, 1'b1), // R11 unknown opcode
      mkv(8'h04, 5'd1, 16'h0000, 5'd2, 16'h0000, 9'd0,   1'b0, 1'b1), // R6 zero length
      mkv(8'h04, 5'd5, 16'h0500, 5'd5, 16'h0502, 9'd6,   1'b0, 1'b0)  // R3 overlapping move
   };

   task automatic run_cmd(input logic [7:0] op, input logic [63:0] prm, input bit exp_err, input bit poke);
      bit [15:0] aa = prm[15:0];
      bit [4:0]  ad = prm[23:19];
      bit [15:0] ba = prm[39:24];
      bit [4:0]  bd = prm[47:43];
      int        ln = int'(prm[56:48]);
      bit        swp = (op == 8'h05);
      bit [67:0] ta [128];
      bit [67:0] tb [128];
      string     tag;
      @(negedge clk);
      chk(cmd_ready, "R8 ready when idle", {67'h0, cmd_ready}, 68'h1);
      cmd_valid = 1'b1; cmd_op = op; cmd_param = prm;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 8'hFF; cmd_param = '1;
      if (exp_err) begin
         if (op != 8'h04 && op != 8'h05) tag = "R11 unknown opcode reject";
         else if (ln < 4 || ln > 128)    tag = "R6 length reject";
         else                            tag = "R7 boundary reject";
         chk(err && !mem_en && !done && cmd_ready, tag,
             {64'h0, err, mem_en, done, cmd_ready}, 68'b1001);
         @(negedge clk);
         chk(!err && !mem_en, {tag, " pulse ends"}, {66'h0, err, mem_en}, 68'h0);
      end else begin
         int        nph = swp ? 4 : 2;
         bit        bad = 1'b0;
         logic [67:0] fa = '0;
         logic [67:0] fe = '0;
         tag = swp ? "R4 swap trace (R1 fields)" : "R2 move trace (R1 fields)";
         for (int p = 0; p < nph; p++) begin
            for (int i = 0; i < ln; i++) begin
               bit        ewe = (p >= nph / 2);
               bit [4:0]  edv = (p % 2 == 0) ? ad : bd;
               bit [15:0] eba = (p % 2 == 0) ? aa : ba;
               logic [67:0] act = {42'h0, mem_en, mem_we, mem_dev, mem_addr, done, cmd_ready, err};
               logic [67:0] exp = {42'h0, 1'b1, ewe, edv, 16'(eba + 16'(i)), 1'b0, 1'b0, 1'b0};
               if (act !== exp && !bad) begin
                  bad = 1'b1; fa = act; fe = exp;
               end
               // R8: a command offered while busy must be ignored
               if (poke && p == 0 && i == 1) begin
                  cmd_valid = 1'b1; cmd_op = 8'h04;
                  cmd_param = mkv(8'h04, 5'd9, 16'h0, 5'd9, 16'h100, 9'd4, 1'b0, 1'b0) >> 1;
               end
               if (poke && p == 0 && i == 3) cmd_valid = 1'b0;
               @(negedge clk);
            end
         end
         chk(!bad, tag, fa, fe);
         chk(done && !mem_en && cmd_ready && !err, "R8 done pulse after last write",
             {64'h0, done, mem_en, cmd_ready, err}, 68'b1010);
         @(negedge clk);
         chk(!done && !mem_en, "R8 done lasts one cycle", {66'h0, done, mem_en}, 68'h0);
         // reference: read all first, then write
         for (int i = 0; i < ln; i++) begin
            ta[i] = rval(key(ad, 16'(aa + 16'(i))));
            tb[i] = rval(key(bd, 16'(ba + 16'(i))));
         end
         for (int i = 0; i < ln; i++)
            if (swp) rmem[key(ad, 16'(aa + 16'(i)))] = tb[i];
         for (int i = 0; i < ln; i++)
            rmem[key(bd, 16'(ba + 16'(i)))] = ta[i];
         bad = 1'b0;
         for (int i = 0; i < ln; i++) begin
            int ka = key(ad, 16'(aa + 16'(i)));
            int kb = key(bd, 16'(ba + 16'(i)));
            if (!bad && dval(ka) != rval(ka)) begin bad = 1'b1; fa = dval(ka); fe = rval(ka); end
            if (!bad && dval(kb) != rval(kb)) begin bad = 1'b1; fa = dval(kb); fe = rval(kb); end
         end
         chk(!bad, swp ? "R5 swap contents" : "R3 move contents", fa, fe);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(cmd_ready && !mem_en && !done && !err, "R10 reset state",
          {64'h0, cmd_ready, mem_en, done, err}, 68'b1000);
      for (int v = 0; v < NV; v++)
         run_cmd(VEC[v][72:65], VEC[v][64:1], VEC[v][0], 1'b0);
      // R8: swap with a command offered mid-burst (ignored)
      run_cmd(8'h05, mkv(8'h05, 5'd2, 16'h0700, 5'd3, 16'h0900, 9'd5, 1'b0, 1'b0) >> 1, 1'b0, 1'b1);
      // R1 R5: second swap back over the same regions restores them
      run_cmd(8'h05, mkv(8'h05, 5'd1, 16'h0300, 5'd4, 16'h0050, 9'd9, 1'b0, 1'b0) >> 1, 1'b0, 1'b0);
      chk(dval(key(5'd1, 16'h0300)) == patt(key(5'd1, 16'h0300)), "R5 double swap restores",
          dval(key(5'd1, 16'h0300)), patt(key(5'd1, 16'h0300)));
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule